// File: doc/BRIEF.md
# Channel-Select Address Dehasher

This block undoes the XOR hashing that a memory fabric applies to the low interleave bits of a physical address. A hashed address arrives with a valid flag. The block works out which of five candidate interleave positions (8, 9, 12, 13, 14) carry hashing in the current configuration. For each selected position it flips the bit back whenever the parity of its enabled higher-order partner bits is odd. The corrected address comes out of a register one cycle later, at a rate of one address per clock.

The set of positions to restore comes from a selection mask. To build the mask, the block forms a contiguous run of ones at bit 8 whose length matches the channel count. It then opens a gap of zeros in that run, and the gap's place and width depend on the interleave granularity. Four page-size enables (64K, 2M, 1G, 1T) decide which partner bits take part in each parity. The mask is registered next to the result so that the channel selection can be observed directly.

Top module: `addr_dehasher`

## Requirements
- R1: While `rst` is high, at each rising edge, `out_valid`, `out_addr` and `out_mask` are cleared to zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. Each accepted address produces exactly one result, in order.
- R3: With `gran_2k` = 0 (1K granularity), `chan_sel` 0/1/2/3 (meaning 2/4/8/16 channels) gives `out_mask` bits {8}, {8,9}, {8,9,12}, {8,9,12,13}. All other mask bits are zero.
- R4: With `gran_2k` = 1 (2K granularity), `chan_sel` 0/1/2/3 gives `out_mask` bits {8}, {8,12}, {8,12,13}, {8,12,13,14}. All other mask bits are zero.
- R5: When mask bit 8 is set, output bit 8 is input bit 8 XOR (a16&e0) XOR (a21&e1) XOR (a30&e2) XOR (a40&e3). Here e = `page_en`, with e0=64K, e1=2M, e2=1G and e3=1T.
- R6: When mask bit 9 is set, output bit 9 is input bit 9 XOR the enabled terms among a17, a22, a31, a41, with the same enable order.
- R7: When mask bit 12 is set, output bit 12 is input bit 12 XOR the enabled terms among a18, a23, a32, a42.
- R8: When mask bit 13 is set, output bit 13 also XORs a19, a24, a33, a43. When mask bit 14 is set, output bit 14 also XORs a20, a25, a34, a44. Each term is gated by e0..e3 in order.
- R9: Address bits outside positions 8, 9, 12, 13 and 14, and any of those five positions whose mask bit is clear, pass through unchanged.
- R10: With `page_en` = 0, `out_addr` equals the accepted `in_addr`, whatever the channel and granularity settings.
- R11: In a cycle with `in_valid` low, `out_addr` and `out_mask` keep their values, even while the other inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the inputs in this cycle |
| in_addr | input | ADDR_W | Hashed address (ADDR_W at least 45) |
| chan_sel | input | 2 | Channel count code: 0=2, 1=4, 2=8, 3=16 |
| gran_2k | input | 1 | 0 = 1K granularity, 1 = 2K granularity |
| page_en | input | 4 | Parity term enables: [0]=64K, [1]=2M, [2]=1G, [3]=1T |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_addr | output | ADDR_W | Dehashed address |
| out_mask | output | 16 | Registered selection mask of positions restored |

## Verification
The hardest cases to reach from the ports are bit 9 and bit 14. Bit 9 is selected only with 1K granularity and at least four channels, and bit 14 only with 2K granularity and sixteen channels. A random address seldom shows whether a single parity term has the right source bit or enable. The stimulus therefore sets one source bit at a time for every lane and every page term. It picks the channel and granularity settings that select that lane, and applies both the matching enable alone and all other enables without it. This shows whether the term flips the target and whether its gating is honoured. Random addresses over random settings then cover pass-through of unselected positions.

// File: rtl/addr_dehash_pkg.sv
package addr_dehash_pkg;

    localparam int MASK_W   = 16;
    localparam int LANES    = 5;
    localparam int BASE_BIT = 8;
    localparam int TERMS    = 4;

    typedef enum logic [1:0] {
        CHAN_2  = 2'd0,
        CHAN_4  = 2'd1,
        CHAN_8  = 2'd2,
        CHAN_16 = 2'd3
    } chan_sel_e;

    typedef logic [MASK_W-1:0] sel_mask_t;

    // Address position restored by lane i: 8, 9, 12, 13, 14
    function automatic int lane_target(input int lane);
        return (lane < 2) ? (BASE_BIT + lane) : (BASE_BIT + 2 + lane);
    endfunction

    // Partner bit for lane and page term (0=64K, 1=2M, 2=1G, 3=1T)
    function automatic int lane_src(input int lane, input int term);
        int base;
        case (term)
            0:       base = 16;
            1:       base = 21;
            2:       base = 30;
            default: base = 40;
        endcase
        return base + lane;
    endfunction

    // Open a run of zero bits of the given width at position 'at'
    function automatic sel_mask_t open_gap(input sel_mask_t v, input int at, input int width);
        sel_mask_t low_keep;
        sel_mask_t upper;
        low_keep = (sel_mask_t'(1) << at) - sel_mask_t'(1);
        upper    = (v >> at) << (at + width);
        return (v & low_keep) | upper;
    endfunction

endpackage

// File: rtl/dehash_mask_gen.sv
module dehash_mask_gen
    import addr_dehash_pkg::*;
(
    input  chan_sel_e chan_sel,
    input  logic      gran_2k,
    output sel_mask_t mask
);
    localparam int RUN_W = 5;

    logic [RUN_W-1:0] run_len;
    sel_mask_t        contig;

    always_comb begin
        run_len = (RUN_W'(2) << chan_sel) - RUN_W'(1);
        contig  = sel_mask_t'(run_len[RUN_W-2:0]) << BASE_BIT;
        if (gran_2k)
            mask = open_gap(contig, BASE_BIT + 1, 3);
        else
            mask = open_gap(contig, BASE_BIT + 2, 2);
    end

endmodule

// File: rtl/dehash_lane.sv
module dehash_lane
    import addr_dehash_pkg::*;
#(
    parameter int ADDR_W = 52,
    parameter int LANE   = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TERMS-1:0]  page_en,
    input  logic              sel,
    output logic              fixed_bit
);
    localparam int TGT = lane_target(LANE);

    logic [TERMS-1:0] partners;
    logic             parity;

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        assign partners[t] = addr[lane_src(LANE, t)];
    end

    always_comb begin
        parity    = ^(partners & page_en);
        fixed_bit = addr[TGT] ^ (sel & parity);
    end

endmodule

// File: rtl/addr_dehasher.sv
module addr_dehasher
    import addr_dehash_pkg::*;
#(
    parameter int ADDR_W = 52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        chan_sel,
    input  logic              gran_2k,
    input  logic [3:0]        page_en,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [15:0]       out_mask
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        sel_mask_t         mask;
    } stage_t;

    sel_mask_t         sel_mask;
    logic [LANES-1:0]  fixed;
    logic [ADDR_W-1:0] next_addr;
    stage_t            stage_q;

    dehash_mask_gen u_mask (
        .chan_sel (chan_sel_e'(chan_sel)),
        .gran_2k  (gran_2k),
        .mask     (sel_mask)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dehash_lane #(.ADDR_W(ADDR_W), .LANE(i)) u_lane (
            .addr      (in_addr),
            .page_en   (page_en),
            .sel       (sel_mask[lane_target(i)]),
            .fixed_bit (fixed[i])
        );
    end

    always_comb begin
        next_addr = in_addr;
        for (int i = 0; i < LANES; i++)
            next_addr[lane_target(i)] = fixed[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.vld <= in_valid;
            if (in_valid) begin
                stage_q.addr <= next_addr;
                stage_q.mask <= sel_mask;
            end
        end
    end

    assign out_valid = stage_q.vld;
    assign out_addr  = stage_q.addr;
    assign out_mask  = stage_q.mask;

endmodule

// File: rtl/addr_dehasher_chk.sv
module addr_dehasher_chk #(
    parameter int ADDR_W = 52
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic [1:0]        chan_sel,
    input logic [3:0]        page_en,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [15:0]       out_mask
);
    localparam logic [ADDR_W-1:0] HASHED_POS = {{(ADDR_W-15){1'b0}}, 15'b111001100000000};

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_addr) && $stable(out_mask)));

    // R9
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (((out_addr ^ $past(in_addr)) & ~HASHED_POS) == '0));

    // R3 R4
    mask_pop_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ($countones(out_mask) == (int'($past(chan_sel)) + 1)));

    // R3 R4
    mask_base_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_mask[8]);

    // R10
    zero_en_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (page_en == 4'b0000)) |=> (out_addr == $past(in_addr)));

endmodule

bind addr_dehasher addr_dehasher_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .chan_sel  (chan_sel),
    .page_en   (page_en),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_mask  (out_mask)
);

// File: tb/addr_dehasher_test.sv
module addr_dehasher_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 52;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [1:0]    chan_sel = 2'd0;
    logic          gran_2k = 1'b0;
    logic [3:0]    page_en = 4'd0;
    logic          out_valid;
    logic [AW-1:0] out_addr;
    logic [15:0]   out_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_dehasher #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .chan_sel(chan_sel), .gran_2k(gran_2k), .page_en(page_en),
        .out_valid(out_valid), .out_addr(out_addr), .out_mask(out_mask)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [15:0]   m;
        string         tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        got;
    exp_t        last_exp;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    function automatic logic [15:0] ref_mask(input logic [1:0] ch, input logic g2k);
        logic [15:0] r = '0;
        for (int k = 0; k <= int'(ch); k++) begin
            int pos = 8 + k;
            if (g2k) begin
                if (k >= 1) pos += 3;
            end else begin
                if (k >= 2) pos += 2;
            end
            r[pos] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] a, input logic [15:0] m,
                                               input logic [3:0] en);
        logic [AW-1:0] r = a;
        int tgt[5] = '{8, 9, 12, 13, 14};
        for (int i = 0; i < 5; i++) begin
            if (m[tgt[i]]) begin
                logic p;
                p = (a[16+i] & en[0]) ^ (a[21+i] & en[1]) ^ (a[30+i] & en[2]) ^ (a[40+i] & en[3]);
                r[tgt[i]] = r[tgt[i]] ^ p;
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] step_rng(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [AW-1:0] a, input logic [1:0] ch, input logic g2k,
                        input logic [3:0] en, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        chan_sel = ch;
        gran_2k  = g2k;
        page_en  = en;
        e.m   = ref_mask(ch, g2k);
        e.a   = ref_addr(a, e.m, en);
        e.tag = tag;
        sb.push_back(e);
        last_exp = e;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            rng      = step_rng(rng);
            in_addr  = rng[AW-1:0];
            chan_sel = rng[1:0];
            gran_2k  = rng[2];
            page_en  = rng[6:3];
        end
    endtask

    // Monitor: compare each result with the oldest expected item
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 64'd1, 64'd0);
            end else begin
                got = sb.pop_front();
                check(out_addr === got.a, got.tag, "out_addr", 64'(out_addr), 64'(got.a));
                check(out_mask === got.m, got.tag, "out_mask", 64'(out_mask), 64'(got.m));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        check(out_addr === '0, "R1", "out_addr in reset", 64'(out_addr), 64'd0);
        check(out_mask === '0, "R1", "out_mask in reset", 64'(out_mask), 64'd0);
        rst = 1'b0;
        idle(2);

        // R3 / R4: mask for every channel count and granularity
        for (int g = 0; g < 2; g++)
            for (int ch = 0; ch < 4; ch++)
                send('0, 2'(ch), 1'(g), 4'hF, (g == 1) ? "R4" : "R3");
        idle(1);
        // R4: two channels, 2K granularity, explicit mask value
        send('0, 2'd0, 1'b1, 4'hF, "R4");
        idle(2);
        check(out_mask === 16'h0100, "R4", "2ch 2K mask", 64'(out_mask), 64'h0100);

        // R5..R8: one partner bit at a time per lane and page term
        for (int i = 0; i < 5; i++) begin
            for (int t = 0; t < 4; t++) begin
                int src;
                string tg;
                logic g2k;
                src = (t == 0) ? 16 + i : (t == 1) ? 21 + i : (t == 2) ? 30 + i : 40 + i;
                tg  = (i == 0) ? "R5" : (i == 1) ? "R6" : (i == 2) ? "R7" : "R8";
                g2k = (i == 1) ? 1'b0 : 1'b1;
                send(AW'(1) << src, 2'd3, g2k, 4'(1 << t), tg);
                send(AW'(1) << src, 2'd3, g2k, ~4'(1 << t), tg);
            end
        end
        idle(1);

        // R9: partner bit 17 set, but bit 9 not selected (2ch, 2K)
        send(AW'(1) << 17, 2'd0, 1'b1, 4'hF, "R9");
        // R9: random addresses over random configurations, back to back
        for (int n = 0; n < 40; n++) begin
            rng = step_rng(rng);
            send(rng[AW-1:0], rng[61:60], rng[59], rng[58:55], "R9");
        end
        idle(1);

        // R10: all page terms off
        for (int n = 0; n < 10; n++) begin
            rng = step_rng(rng);
            send(rng[AW-1:0], rng[61:60], rng[59], 4'h0, "R10");
        end

        // R11: results hold while inputs change with in_valid low
        idle(4);
        check(out_valid === 1'b0, "R11", "out_valid idle", 64'(out_valid), 64'd0);
        check(out_addr === last_exp.a, "R11", "out_addr hold", 64'(out_addr), 64'(last_exp.a));
        check(out_mask === last_exp.m, "R11", "out_mask hold", 64'(out_mask), 64'(last_exp.m));

        // R2: every accepted address produced one result
        check(sb.size() == 0, "R2", "pending results", 64'(sb.size()), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule